// File: doc/BRIEF.md
# Message-Signalled Interrupt Source Engine with Pending/Queued Gating

This block turns interrupt triggers for a bank of sources into delivered interrupts. Each source owns an eight-byte descriptor in system memory that holds its target server, its priority, an owner tag, a generation value and two marks: P (an interrupt is in flight) and Q (another trigger arrived while one was in flight). A trigger comes either as an inbound message (address and data words from which the source number is extracted) or as a direct line event that names the source and may be forced.

For each accepted trigger the engine checks the source number against the configured source count and the descriptor table limits, computes the descriptor address, reads the descriptor over a simple request/response memory port and decides from the P/Q marks and priority whether to deliver, queue or drop. It writes the updated mark byte back into the descriptor itself and, when delivering, emits a one-cycle pulse carrying the server, source number and priority. One trigger is handled at a time; a busy flag holds off the next one.

Top module: `msi_pq_engine`

## Requirements
- R1: For a message trigger the source number is `msg_addr_i[19:4] | msg_data_i[4:0]`; if it is not below `src_count_i`, the trigger makes no memory access and delivers nothing. Direct triggers use `trig_src_i` and skip this count check.
- R2: When `tbl_en_i` is 0, an accepted trigger makes no memory access and delivers nothing.
- R3: A source number greater than or equal to `tbl_len_i` makes no memory access and delivers nothing; a source number one below the limit is processed.
- R4: The descriptor address is `tbl_base_i` with its low 7 bits cleared, plus the source number times 128 when `big_ent_i` is 1 or times 16 when it is 0. The descriptor is read as one 8-byte access at that address, and mark writes go to address +4 (P byte) or +5 (Q byte).
- R5: The descriptor is big-endian: bytes 0-1 hold the raw server, of which the delivered server is the raw value shifted right by 2; bytes 2-3 hold the owner tag; byte 4 bit 0 is P and bits 2:1 are the generation; byte 5 bit 0 is Q; byte 6 is the priority. The state is {P, Q}.
- R6: With state 00 and priority not 0xFF, the engine writes byte `{5'b0, gen, 1'b1}` at +4 and then pulses `irq_vld_o` for one cycle with the server, source number and priority.
- R7: With state 00 and priority 0xFF the engine writes 0x01 at +5 and delivers nothing.
- R8: With state 10 the engine writes 0x01 at +5 and delivers nothing; with state 01 or 11 it writes nothing and delivers nothing.
- R9: A forced direct trigger (`trig_force_i` = 1) is treated as state 00 whatever the stored P and Q bits are.
- R10: A message trigger with `tag_vld_i` = 1 whose `tag_i` differs from the descriptor owner tag writes nothing and delivers nothing; a matching tag is processed normally.
- R11: A trigger is accepted when `trig_vld_i` is 1 and `busy_o` is 0; `busy_o` is 1 from the next cycle until the trigger is finished, at most one memory request is outstanding, and a request is held stable until its response.
- R12: A response with `mem_err_i` = 1 pulses `err_o` for one cycle and abandons the trigger: no delivery and no further memory access for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_vld_i | input | 1 | Trigger request |
| trig_msg_i | input | 1 | 1: message trigger, 0: direct trigger |
| msg_addr_i | input | ADDR_W | Inbound message address |
| msg_data_i | input | 16 | Inbound message data |
| trig_src_i | input | SRC_W | Source number of a direct trigger |
| trig_force_i | input | 1 | Force state 00 (direct triggers only) |
| tag_vld_i | input | 1 | Owner tag supplied (message triggers only) |
| tag_i | input | 16 | Owner tag of the sender |
| busy_o | output | 1 | Trigger in progress |
| src_count_i | input | SRC_W+1 | Number of sources reachable by messages |
| tbl_en_i | input | 1 | Descriptor table enable |
| tbl_len_i | input | SRC_W+1 | Descriptor table length in entries |
| tbl_base_i | input | ADDR_W | Descriptor table base address |
| big_ent_i | input | 1 | 128-byte descriptor stride when 1, 16-byte otherwise |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1: byte write, 0: 8-byte read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rvalid_i | input | 1 | Response for the current request |
| mem_rdata_i | input | 64 | Read data, byte 0 in the top bits |
| mem_err_i | input | 1 | Response carries an error |
| irq_vld_o | output | 1 | Delivery pulse |
| irq_server_o | output | 14 | Target server |
| irq_src_o | output | SRC_W | Source number |
| irq_prio_o | output | 8 | Priority |
| err_o | output | 1 | Memory error pulse |

## Verification
The bench aims at the P/Q decision table at every state, including the masked priority, the forced trigger on a queued source and the owner-tag mismatch; a wrong decode would deliver twice, lose a queued trigger or send a masked interrupt. It probes the limits exactly at the source count and table length and the 16/128-byte stride, where an off-by-one compare or a wrong shift would read or corrupt a neighbouring descriptor. Errors are injected on both the read and the write-back; a design that ignored them would still deliver or would leave a half-updated descriptor.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int TAG_W = 16;
  localparam int SRV_W = 14;
  localparam int PRIO_W = 8;
  localparam int GEN_W = 2;
  localparam int ALIGN_B = 7;
  localparam logic [PRIO_W-1:0] PRIO_MASKED = 8'hFF;
  localparam int OFF_PMARK = 4;
  localparam int OFF_QMARK = 5;

  // big-endian descriptor, byte 0 in bits 63:56
  typedef struct packed {
    logic [15:0]       srv_raw;
    logic [TAG_W-1:0]  owner;
    logic [4:0]        rsv4;
    logic [GEN_W-1:0]  gen;
    logic              p;
    logic [6:0]        rsv5;
    logic              q;
    logic [PRIO_W-1:0] prio;
    logic [7:0]        rsv7;
  } ent_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_RD, ST_EVAL, ST_WP, ST_WQ
  } st_e;

  typedef enum logic [1:0] {
    ACT_DROP, ACT_SETQ, ACT_SETP
  } act_e;
endpackage

// File: rtl/msi_src_decode.sv
module msi_src_decode #(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 16
) (
  input  logic              is_msg_i,
  input  logic [ADDR_W-1:0] msg_addr_i,
  input  logic [15:0]       msg_data_i,
  input  logic [SRC_W-1:0]  dir_src_i,
  input  logic [SRC_W:0]    src_count_i,
  output logic [SRC_W-1:0]  src_o,
  output logic              cnt_ok_o
);
  localparam int MSG_SRC_W = 16;

  logic [MSG_SRC_W-1:0] msg_src;
  logic [MSG_SRC_W:0]   msg_src_x;
  logic                 unused_ok;

  assign msg_src   = msg_addr_i[19:4] | {11'd0, msg_data_i[4:0]};
  assign msg_src_x = {1'b0, msg_src};
  assign unused_ok = ^{msg_addr_i[ADDR_W-1:20], msg_addr_i[3:0], msg_data_i[15:5]};

  always_comb begin
    if (is_msg_i) begin
      src_o    = SRC_W'(msg_src);
      cnt_ok_o = (MSG_SRC_W+1 > SRC_W+1) ? (msg_src_x < (MSG_SRC_W+1)'(src_count_i))
                                         : ((SRC_W+1)'(msg_src_x) < src_count_i);
    end else begin
      src_o    = dir_src_i;
      cnt_ok_o = 1'b1;
    end
  end
endmodule

// File: rtl/msi_ent_addr.sv
module msi_ent_addr
  import msi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 16
) (
  input  logic [SRC_W-1:0]  src_i,
  input  logic              tbl_en_i,
  input  logic [SRC_W:0]    tbl_len_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              big_ent_i,
  output logic              tbl_ok_o,
  output logic [ADDR_W-1:0] ent_addr_o
);
  localparam int SH_BIG   = 7;
  localparam int SH_SMALL = 4;

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] src_x;
  logic [ADDR_W-1:0] stride_off;
  logic              unused_ok;

  assign base_al   = {tbl_base_i[ADDR_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
  assign unused_ok = ^tbl_base_i[ALIGN_B-1:0];

  generate
    if (ADDR_W >= SRC_W) begin : g_zext
      assign src_x = ADDR_W'(src_i);
    end else begin : g_trunc
      assign src_x = src_i[ADDR_W-1:0];
    end
  endgenerate

  assign stride_off = big_ent_i ? (src_x << SH_BIG) : (src_x << SH_SMALL);
  assign tbl_ok_o   = tbl_en_i && ({1'b0, src_i} < tbl_len_i);
  assign ent_addr_o = base_al + stride_off;
endmodule

// File: rtl/msi_pq_eval.sv
module msi_pq_eval
  import msi_pkg::*;
(
  input  ent_t               ent_i,
  input  logic               force_i,
  input  logic               tag_vld_i,
  input  logic [TAG_W-1:0]   tag_i,
  output act_e               act_o,
  output logic [7:0]         pmark_o,
  output logic [SRV_W-1:0]   server_o,
  output logic [PRIO_W-1:0]  prio_o
);
  logic [1:0] pq;
  logic       unused_ok;

  assign pq        = force_i ? 2'b00 : {ent_i.p, ent_i.q};
  assign pmark_o   = {5'd0, ent_i.gen, 1'b1};
  assign server_o  = ent_i.srv_raw[15:2];  // low two bits are a link pointer
  assign prio_o    = ent_i.prio;
  assign unused_ok = ^{ent_i.rsv4, ent_i.rsv5, ent_i.rsv7, ent_i.srv_raw[1:0]};

  always_comb begin
    act_o = ACT_DROP;
    if (!(tag_vld_i && (tag_i != ent_i.owner))) begin
      unique case (pq)
        2'b00:   act_o = (ent_i.prio == PRIO_MASKED) ? ACT_SETQ : ACT_SETP;
        2'b10:   act_o = ACT_SETQ;
        default: act_o = ACT_DROP;
      endcase
    end
  end
endmodule

// File: rtl/msi_pq_engine.sv
module msi_pq_engine
  import msi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRC_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   trig_vld_i,
  input  logic                   trig_msg_i,
  input  logic [ADDR_W-1:0]      msg_addr_i,
  input  logic [15:0]            msg_data_i,
  input  logic [SRC_W-1:0]       trig_src_i,
  input  logic                   trig_force_i,
  input  logic                   tag_vld_i,
  input  logic [TAG_W-1:0]       tag_i,
  output logic                   busy_o,
  input  logic [SRC_W:0]         src_count_i,
  input  logic                   tbl_en_i,
  input  logic [SRC_W:0]         tbl_len_i,
  input  logic [ADDR_W-1:0]      tbl_base_i,
  input  logic                   big_ent_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [7:0]             mem_wdata_o,
  input  logic                   mem_rvalid_i,
  input  logic [63:0]            mem_rdata_i,
  input  logic                   mem_err_i,
  output logic                   irq_vld_o,
  output logic [SRV_W-1:0]       irq_server_o,
  output logic [SRC_W-1:0]       irq_src_o,
  output logic [PRIO_W-1:0]      irq_prio_o,
  output logic                   err_o
);
  st_e                st_q;
  logic [SRC_W-1:0]   src_q;
  logic               cnt_ok_q;
  logic               force_q;
  logic               tag_vld_q;
  logic [TAG_W-1:0]   tag_q;
  ent_t               ent_q;

  logic [SRC_W-1:0]   dec_src;
  logic               dec_cnt_ok;
  logic               tbl_ok;
  logic [ADDR_W-1:0]  ent_addr;
  act_e               act;
  logic [7:0]         pmark;
  logic [SRV_W-1:0]   ev_server;
  logic [PRIO_W-1:0]  ev_prio;

  msi_src_decode #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_dec (
    .is_msg_i    (trig_msg_i),
    .msg_addr_i  (msg_addr_i),
    .msg_data_i  (msg_data_i),
    .dir_src_i   (trig_src_i),
    .src_count_i (src_count_i),
    .src_o       (dec_src),
    .cnt_ok_o    (dec_cnt_ok)
  );

  msi_ent_addr #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_addr (
    .src_i      (src_q),
    .tbl_en_i   (tbl_en_i),
    .tbl_len_i  (tbl_len_i),
    .tbl_base_i (tbl_base_i),
    .big_ent_i  (big_ent_i),
    .tbl_ok_o   (tbl_ok),
    .ent_addr_o (ent_addr)
  );

  msi_pq_eval u_eval (
    .ent_i     (ent_q),
    .force_i   (force_q),
    .tag_vld_i (tag_vld_q),
    .tag_i     (tag_q),
    .act_o     (act),
    .pmark_o   (pmark),
    .server_o  (ev_server),
    .prio_o    (ev_prio)
  );

  assign busy_o    = (st_q != ST_IDLE);
  assign mem_req_o = (st_q == ST_RD) || (st_q == ST_WP) || (st_q == ST_WQ);
  assign mem_we_o  = (st_q == ST_WP) || (st_q == ST_WQ);

  always_comb begin
    unique case (st_q)
      ST_WP:   begin mem_addr_o = ent_addr + ADDR_W'(OFF_PMARK); mem_wdata_o = pmark; end
      ST_WQ:   begin mem_addr_o = ent_addr + ADDR_W'(OFF_QMARK); mem_wdata_o = 8'h01; end
      default: begin mem_addr_o = ent_addr;                      mem_wdata_o = 8'h00; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      src_q        <= '0;
      cnt_ok_q     <= 1'b0;
      force_q      <= 1'b0;
      tag_vld_q    <= 1'b0;
      tag_q        <= '0;
      ent_q        <= '0;
      irq_vld_o    <= 1'b0;
      irq_server_o <= '0;
      irq_src_o    <= '0;
      irq_prio_o   <= '0;
      err_o        <= 1'b0;
    end else begin
      irq_vld_o <= 1'b0;
      err_o     <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (trig_vld_i) begin
          src_q     <= dec_src;
          cnt_ok_q  <= dec_cnt_ok;
          force_q   <= !trig_msg_i && trig_force_i;
          tag_vld_q <= trig_msg_i && tag_vld_i;
          tag_q     <= tag_i;
          st_q      <= ST_CHK;
        end
        ST_CHK: st_q <= (cnt_ok_q && tbl_ok) ? ST_RD : ST_IDLE;
        ST_RD: if (mem_rvalid_i) begin
          if (mem_err_i) begin
            err_o <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            ent_q <= ent_t'(mem_rdata_i);
            st_q  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          unique case (act)
            ACT_SETP: st_q <= ST_WP;
            ACT_SETQ: st_q <= ST_WQ;
            default:  st_q <= ST_IDLE;
          endcase
        end
        ST_WP: if (mem_rvalid_i) begin
          st_q <= ST_IDLE;
          if (mem_err_i) begin
            err_o <= 1'b1;
          end else begin
            irq_vld_o    <= 1'b1;
            irq_server_o <= ev_server;
            irq_src_o    <= src_q;
            irq_prio_o   <= ev_prio;
          end
        end
        ST_WQ: if (mem_rvalid_i) begin
          st_q  <= ST_IDLE;
          err_o <= mem_err_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_vld_i && !busy_o |=> busy_o); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R11
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
  AST_MARK_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> (mem_addr_o[3:0] == 4'd4) || (mem_addr_o[3:0] == 4'd5)); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vld_o |=> !irq_vld_o); // R6
  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_vld_o |-> irq_prio_o != PRIO_MASKED); // R7
  AST_ERR_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !irq_vld_o && !busy_o); // R12
endmodule

// File: tb/msi_pq_engine_tb.sv
module msi_pq_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int SRC_W  = 16;
  localparam int MEM_SZ = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              trig_vld = 0, trig_msg = 0, trig_force = 0, tag_vld = 0;
  logic [ADDR_W-1:0] msg_addr = 0;
  logic [15:0]       msg_data = 0, tag = 0;
  logic [SRC_W-1:0]  trig_src = 0;
  logic              busy;
  logic [SRC_W:0]    cfg_cnt = 17'd32, cfg_len = 17'd32;
  logic              cfg_en = 1, cfg_big = 0;
  logic [ADDR_W-1:0] cfg_base = 32'h0000_0400;
  logic              mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic              mem_rvalid = 0, mem_err = 0;
  logic [63:0]       mem_rdata = 0;
  logic              irq_vld, err;
  logic [13:0]       irq_server;
  logic [SRC_W-1:0]  irq_src;
  logic [7:0]        irq_prio;

  msi_pq_engine #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .trig_vld_i(trig_vld), .trig_msg_i(trig_msg), .msg_addr_i(msg_addr), .msg_data_i(msg_data),
    .trig_src_i(trig_src), .trig_force_i(trig_force), .tag_vld_i(tag_vld), .tag_i(tag),
    .busy_o(busy),
    .src_count_i(cfg_cnt), .tbl_en_i(cfg_en), .tbl_len_i(cfg_len), .tbl_base_i(cfg_base), .big_ent_i(cfg_big),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .irq_vld_o(irq_vld), .irq_server_o(irq_server), .irq_src_o(irq_src), .irq_prio_o(irq_prio),
    .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] bmem [MEM_SZ];
  int rd_cnt = 0, wr_cnt = 0, irq_cnt = 0, err_cnt = 0, dly = 0;
  bit err_rd_arm = 0, err_wr_arm = 0;
  logic [13:0] cap_server;
  logic [SRC_W-1:0] cap_src;
  logic [7:0] cap_prio;

  // memory model: one response per request after a random delay
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    mem_err    <= 1'b0;
    if (mem_req && !mem_rvalid) begin
      if (dly == 0) begin
        mem_rvalid <= 1'b1;
        dly = $urandom_range(0, 3);
        if (mem_we) begin
          wr_cnt++;
          if (err_wr_arm) begin mem_err <= 1'b1; err_wr_arm = 0; end
          else bmem[mem_addr[12:0]] = mem_wdata;
        end else begin
          rd_cnt++;
          if (err_rd_arm) begin mem_err <= 1'b1; err_rd_arm = 0; end
          for (int k = 0; k < 8; k++) mem_rdata[63-8*k -: 8] <= bmem[13'(mem_addr[12:0] + 13'(k))];
        end
      end else dly--;
    end
    if (irq_vld) begin
      irq_cnt++;
      cap_server = irq_server; cap_src = irq_src; cap_prio = irq_prio;
    end
    if (err) err_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int ent_addr(input logic [15:0] s);
    return int'({cfg_base[31:7], 7'd0}) + (cfg_big ? int'(s) * 128 : int'(s) * 16);
  endfunction

  task automatic set_ent(input logic [15:0] s, input logic [15:0] srv, input logic [15:0] own,
                         input bit p, input logic [1:0] gen, input bit q, input logic [7:0] prio);
    int a = ent_addr(s);
    bmem[a] = srv[15:8]; bmem[a+1] = srv[7:0];
    bmem[a+2] = own[15:8]; bmem[a+3] = own[7:0];
    bmem[a+4] = {5'd0, gen, p}; bmem[a+5] = {7'd0, q};
    bmem[a+6] = prio; bmem[a+7] = 8'h5A;
  endtask

  // rq names the requirement under test
  task automatic run_trig(input bit msg, input logic [31:0] addr, input logic [15:0] data,
                          input logic [15:0] dsrc, input bit frc, input bit tv, input logic [15:0] tg,
                          input bit tg_match, input string rq);
    logic [15:0] s, own, srv;
    logic [7:0] b4, b5, prio, e4, e5;
    bit reach, rerr, werr, is_msg_drop;
    int a, act, rd0, wr0, irq0, err0, exp_rd, exp_wr, exp_irq, exp_err, to;
    logic [1:0] pq;
    s = msg ? (addr[19:4] | {11'd0, data[4:0]}) : dsrc;
    is_msg_drop = msg && ({1'b0, s} >= cfg_cnt);
    reach = !is_msg_drop && cfg_en && ({1'b0, s} < cfg_len);
    a = reach ? ent_addr(s) : 0;
    rerr = err_rd_arm; werr = err_wr_arm;
    act = 0; e4 = 0; e5 = 0; srv = 0; prio = 0; own = 0;
    if (reach) begin
      srv = {bmem[a], bmem[a+1]}; own = {bmem[a+2], bmem[a+3]};
      b4 = bmem[a+4]; b5 = bmem[a+5]; prio = bmem[a+6];
      if (tg_match) tg = own;
      pq = (!msg && frc) ? 2'b00 : {b4[0], b5[0]};
      if (msg && tv && tg != own) act = 0;
      else if (pq == 2'b00) act = (prio == 8'hFF) ? 1 : 2;
      else if (pq == 2'b10) act = 1;
      else act = 0;
      e4 = b4; e5 = b5;
      if (!rerr && !werr) begin
        if (act == 2) e4 = {5'd0, b4[2:1], 1'b1};
        if (act == 1) e5 = 8'h01;
      end
    end
    exp_rd  = reach ? 1 : 0;
    exp_wr  = (reach && !rerr && act != 0) ? 1 : 0;
    exp_irq = (reach && !rerr && !werr && act == 2) ? 1 : 0;
    exp_err = (reach && (rerr || (act != 0 && werr))) ? 1 : 0;
    rd0 = rd_cnt; wr0 = wr_cnt; irq0 = irq_cnt; err0 = err_cnt;
    @(negedge clk);
    trig_vld = 1; trig_msg = msg; msg_addr = addr; msg_data = data;
    trig_src = dsrc; trig_force = frc; tag_vld = tv; tag = tg;
    @(negedge clk);
    trig_vld = 0;
    chk(busy === 1'b1, "R11", "busy after accept", busy, 1);
    to = 0;
    while (busy && to < 200) begin @(negedge clk); to++; end
    if (to >= 200) chk(0, "R11", "busy timeout", to, 0);
    @(negedge clk); @(negedge clk);
    err_rd_arm = 0; err_wr_arm = 0;
    chk(rd_cnt - rd0 == exp_rd, rq, "read count", rd_cnt - rd0, exp_rd);
    chk(wr_cnt - wr0 == exp_wr, rq, "write count", wr_cnt - wr0, exp_wr);
    chk(irq_cnt - irq0 == exp_irq, rq, "delivery count", irq_cnt - irq0, exp_irq);
    chk(err_cnt - err0 == exp_err, rq, "error count", err_cnt - err0, exp_err);
    if (reach) begin
      chk(bmem[a+4] == e4, rq, "P byte", bmem[a+4], e4);
      chk(bmem[a+5] == e5, rq, "Q byte", bmem[a+5], e5);
    end
    if (exp_irq == 1 && irq_cnt - irq0 == 1) begin
      chk(cap_server == srv[15:2], "R5", "server", cap_server, srv[15:2]);
      chk(cap_src == s, rq, "source", cap_src, s);
      chk(cap_prio == prio, rq, "priority", cap_prio, prio);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D));
    for (int i = 0; i < MEM_SZ; i++) bmem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && irq_vld === 1'b0 && mem_req === 1'b0 && err === 1'b0,
        "R11", "reset outputs", {busy, irq_vld, mem_req, err}, 0);
    rst_n = 1;
    @(negedge clk);

    // R6: idle source delivers, server shifted
    set_ent(16'd3, 16'hABCF, 16'h1234, 0, 2'd2, 0, 8'h20);
    run_trig(0, 0, 0, 16'd3, 0, 0, 0, 0, "R6");
    // R8: now pending -> queue
    run_trig(0, 0, 0, 16'd3, 0, 0, 0, 0, "R8");
    // R8: pending+queued -> drop
    run_trig(0, 0, 0, 16'd3, 0, 0, 0, 0, "R8");
    // R9: forced on state 11 delivers
    run_trig(0, 0, 0, 16'd3, 1, 0, 0, 0, "R9");
    // R8: state 01 dropped
    set_ent(16'd4, 16'h0010, 16'h0, 0, 2'd1, 1, 8'h05);
    run_trig(0, 0, 0, 16'd4, 0, 0, 0, 0, "R8");
    // R7: masked priority only queues
    set_ent(16'd5, 16'h0020, 16'h0, 0, 2'd3, 0, 8'hFF);
    run_trig(0, 0, 0, 16'd5, 0, 0, 0, 0, "R7");
    // R2: table disabled
    set_ent(16'd6, 16'h0030, 16'h0, 0, 2'd0, 0, 8'h10);
    cfg_en = 0;
    run_trig(0, 0, 0, 16'd6, 0, 0, 0, 0, "R2");
    cfg_en = 1;
    // R3: length boundary
    cfg_len = 17'd10;
    set_ent(16'd9, 16'h0044, 16'h0, 0, 2'd1, 0, 8'h11);
    run_trig(0, 0, 0, 16'd10, 0, 0, 0, 0, "R3");
    run_trig(0, 0, 0, 16'd9, 0, 0, 0, 0, "R3");
    cfg_len = 17'd32;
    // R1: message source from address OR data; count boundary
    cfg_cnt = 17'd20;
    set_ent(16'd19, 16'h0104, 16'h0, 0, 2'd0, 0, 8'h07);
    run_trig(1, 32'h0000_0100, 16'hFFE3, 0, 0, 0, 0, 0, "R1");
    run_trig(1, 32'h0000_0140, 16'h0000, 0, 0, 0, 0, 0, "R1");
    cfg_cnt = 17'd32;
    // R10: owner tag mismatch then match
    set_ent(16'd7, 16'h0208, 16'hBEEF, 0, 2'd0, 0, 8'h33);
    run_trig(1, 32'h0000_0070, 0, 0, 0, 1, 16'hBEEE, 0, "R10");
    run_trig(1, 32'h0000_0070, 0, 0, 0, 1, 16'hBEEF, 0, "R10");
    // R4: 128-byte stride
    cfg_big = 1;
    set_ent(16'd12, 16'h0300, 16'h0, 0, 2'd1, 0, 8'h40);
    run_trig(0, 0, 0, 16'd12, 0, 0, 0, 0, "R4");
    cfg_big = 0;
    // R12: errors on read and on write-back
    set_ent(16'd8, 16'h0400, 16'h0, 0, 2'd0, 0, 8'h21);
    err_rd_arm = 1;
    run_trig(0, 0, 0, 16'd8, 0, 0, 0, 0, "R12");
    err_wr_arm = 1;
    run_trig(0, 0, 0, 16'd8, 0, 0, 0, 0, "R12");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] rs, dat;
      logic [31:0] ad;
      bit m;
      if (n % 50 == 0) begin
        cfg_en  = ($urandom_range(0, 9) != 0);
        cfg_len = 17'($urandom_range(8, 40));
        cfg_cnt = 17'($urandom_range(8, 48));
        cfg_big = 1'($urandom);
      end
      m  = 1'($urandom);
      rs = 16'($urandom_range(0, 47));
      ad = {12'($urandom), 16'($urandom_range(0, 47)), 4'($urandom)};
      dat = ($urandom_range(0, 1) == 0) ? 16'($urandom) & 16'hFFE0 : 16'($urandom);
      if ({1'b0, rs} < cfg_len && $urandom_range(0, 9) < 4)
        set_ent(rs, 16'($urandom), 16'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom));
      if ($urandom_range(0, 19) == 0) err_rd_arm = 1;
      else if ($urandom_range(0, 19) == 0) err_wr_arm = 1;
      run_trig(m, ad, dat, rs, 1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule